// File: doc/BRIEF.md
# Serial Memory Programming Port

This block is the device-side end of a three-wire programming link. An external programmer uses it to read and write the on-chip nonvolatile store. The programmer drives a phase select (`load_i`), a slow serial clock (`sclk_i`) and a serial data line (`sdi_i`). The block answers on `sdo_o`. All three inputs are sampled by the fast internal clock through synchronisers, and the serial clock is edge-detected. The programmer's clock therefore has to be several internal cycles long in each half period.

Each transaction has two phases. While `load_i` is high, a 32-bit command is shifted in, most significant bit first. At the same time, the response word of the previous executed command is shifted out, so responses arrive one command late. The programmer then drops `load_i` and gives two clock pulses, and the second pulse executes the command. A read latches the addressed byte into the low byte of the next response. A write starts a program cycle, and while that cycle runs `sdo_o` is held low as a busy flag. Page-mode writes collect bytes in a page buffer, and the buffer is committed in a single program cycle. A behavioural array with a configurable program latency stands in for the nonvolatile cells. It has two spaces, code and data.

Top module: `nvm_serial_port`

## Requirements
- R1: After reset `sdo_o` is high while `load_i` is low, and the response word shifted out during the first command after reset is all zeros.
- R2: While `load_i` is high, each rising `sclk_i` edge shifts `sdi_i` into the command register, MSB first. The command that executes is the last 32 bits shifted before `load_i` fell.
- R3: After the k-th rising `sclk_i` edge of a `load_i`-high phase, `sdo_o` presents bit 32-k of the response of the most recently executed command.
- R4: A command executes only on the second rising `sclk_i` edge while `load_i` is low. A low phase with a single pulse changes neither memory nor the pending response.
- R5: Command fields are as follows. Bit 31 selects page mode. Bit 29 selects the data space and bit 28 the code space. Bit 24 is 1 for read and 0 for write. Bit 22 is erase. Bits 17:8 hold the address and bits 7:0 hold the data. Bits 30, 27:25, 23 and 21:18 are reserved zero. Response bits 31:8 echo command bits 31:8.
- R6: A valid read returns in response bits 7:0 the byte stored at the addressed location of the selected space. A location that was never written reads 8'hFF.
- R7: A valid byte-mode write stores its data and echoes the whole command. `sdo_o` is low before the second execute pulse ends, and it stays low for at least WRITE_CYCLES internal cycles before returning high.
- R8: A write with the erase bit set stores 8'hFF instead of its data byte.
- R9: A page-mode write whose address offset (the address bits below log2 PAGE_BYTES) is not the last offset only fills the page buffer. Memory is unchanged and `sdo_o` stays high.
- R10: A page-mode write at the last offset commits every buffered offset plus its own byte into the page of its address, raises busy as in R7, and empties the buffer.
- R11: A command is ignored if it has a nonzero reserved bit, both or neither space bits, or read together with erase. It changes no memory, raises no busy, and its response is command bits 31:8 with bits 7:0 zero.
- R12: The code and data spaces are distinct: the same address in each space holds an independent byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Phase select: high to shift, low to execute |
| sclk_i | input | 1 | Programmer serial clock, asynchronous |
| sdi_i | input | 1 | Serial command data, MSB first |
| sdo_o | output | 1 | Serial response data; low while a program cycle runs |

## Verification
Each synchronised `sclk_i` rise takes effect on the third internal edge after the pin changes, and `sdo_o` follows one edge later. The bench therefore holds each serial-clock half for six internal cycles and samples `sdo_o` just before the serial clock falls. A read's byte only shows up in the shift phase after its execute phase, so the bench model keeps the pending response and compares each whole shifted word against it. For writes, busy is checked at the end of the second pulse's high half. The bench then counts internal cycles until `sdo_o` rises and requires the count to lie between WRITE_CYCLES and WRITE_CYCLES plus the synchroniser delay.

// File: rtl/nvm_pgm_pkg.sv
package nvm_pgm_pkg;

    localparam int CMD_W  = 32;
    localparam int FLD_AW = 10;

    // command / response word, bit 31 first
    typedef struct packed {
        logic              page;
        logic              rsv30;
        logic              dspace;
        logic              cspace;
        logic [2:0]        rsv27;
        logic              rd;
        logic              rsv23;
        logic              erase;
        logic [3:0]        rsv21;
        logic [FLD_AW-1:0] addr;
        logic [7:0]        data;
    } cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_DONE  = 2'd2
    } exec_ph_e;

    function automatic logic cmd_ok(input cmd_t c);
        return (c.rsv30 == 1'b0) && (c.rsv27 == 3'd0) && (c.rsv23 == 1'b0) &&
               (c.rsv21 == 4'd0) && (c.dspace ^ c.cspace) && !(c.rd && c.erase);
    endfunction

    function automatic logic [CMD_W-1:0] resp_of(input cmd_t c, input logic ok,
                                                  input logic [7:0] rdata);
        logic [7:0] lo;
        if (!ok)       lo = 8'h00;
        else if (c.rd) lo = rdata;
        else           lo = c.data;
        return {c[CMD_W-1:8], lo};
    endfunction

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] stg [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q   = stg[STAGES-1];
    assign q_d = stg[STAGES];
endmodule

// File: rtl/pgm_shifter.sv
module pgm_shifter
    import nvm_pgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             sdi,
    input  logic             resp_ld,
    input  logic [CMD_W-1:0] resp_val,
    output logic [CMD_W-1:0] cmd_word,
    output logic [CMD_W-1:0] resp_word,
    output logic             out_bit
);
    // response rotates, so a full 32-bit phase leaves it intact
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word  <= '0;
            resp_word <= '0;
            out_bit   <= 1'b0;
        end else if (shift_en) begin
            cmd_word  <= {cmd_word[CMD_W-2:0], sdi};
            out_bit   <= resp_word[CMD_W-1];
            resp_word <= {resp_word[CMD_W-2:0], resp_word[CMD_W-1]};
        end else if (resp_ld) begin
            resp_word <= resp_val;
        end
    end
endmodule

// File: rtl/nvm_model.sv
module nvm_model #(
    parameter int AW           = 10,
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW:0]   idx,
    output logic [7:0]    rd_data,
    input  logic [7:0]    wdata,
    input  logic          wr_go,
    input  logic          pg_put,
    input  logic          pg_commit,
    output logic          busy_o
);
    localparam int DEPTH = 2 ** (AW + 1);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [CNT_W-1:0]      cnt;
    logic [PG_W-1:0]       off;
    logic [AW-PG_W:0]      base;

    assign off     = idx[PG_W-1:0];
    assign base    = idx[AW:PG_W];
    assign rd_data = mem[idx];
    assign busy_o  = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_go) begin
            mem[idx] <= wdata;
        end else if (pg_commit) begin
            for (int o = 0; o < PAGE_BYTES; o++) begin
                if (PG_W'(o) == off)
                    mem[{base, PG_W'(o)}] <= wdata;
                else if (pmask[o])
                    mem[{base, PG_W'(o)}] <= pbuf[o];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask <= '0;
            for (int o = 0; o < PAGE_BYTES; o++) pbuf[o] <= 8'h00;
        end else if (pg_commit) begin
            pmask <= '0;
        end else if (pg_put) begin
            pbuf[off]  <= wdata;
            pmask[off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (wr_go || pg_commit)   cnt <= CNT_W'(WRITE_CYCLES);
        else if (cnt != '0)            cnt <= cnt - 1'b1;
    end

    // R7: the port never starts a program cycle on top of a running one
    assert_start_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_go || pg_commit) |-> !busy_o);
endmodule

// File: rtl/nvm_serial_port.sv
module nvm_serial_port
    import nvm_pgm_pkg::*;
#(
    parameter int MEM_AW       = 10,
    parameter int PAGE_BYTES   = 8,
    parameter int WRITE_CYCLES = 40,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    logic [2:0] pins_s, pins_d;
    logic       load_s, sclk_s, sdi_s, sclk_rise;

    pgm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({load_i, sclk_i, sdi_i}),
        .q   (pins_s),
        .q_d (pins_d)
    );

    assign {load_s, sclk_s, sdi_s} = pins_s;
    assign sclk_rise = sclk_s && !pins_d[1];

    exec_ph_e         ph;
    cmd_t             cmd_q;
    logic [CMD_W-1:0] cmd_word, resp_word;
    logic             out_bit, busy, exec, ok;
    logic             wr_go, pg_put, pg_commit;
    logic [7:0]       rd_data, wdata;
    logic [MEM_AW:0]  idx;

    pgm_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (sclk_rise && load_s),
        .sdi       (sdi_s),
        .resp_ld   (exec),
        .resp_val  (resp_of(cmd_q, ok, rd_data)),
        .cmd_word  (cmd_word),
        .resp_word (resp_word),
        .out_bit   (out_bit)
    );

    // pulse counting for the execute phase
    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cmd_q <= '0;
        end else if (load_s) begin
            ph <= PH_IDLE;
        end else if (sclk_rise) begin
            case (ph)
                PH_IDLE: begin
                    ph    <= PH_ARMED;
                    cmd_q <= cmd_t'(cmd_word);
                end
                PH_ARMED: ph <= PH_DONE;
                default:  ph <= PH_DONE;
            endcase
        end
    end

    assign exec      = sclk_rise && !load_s && (ph == PH_ARMED) && !busy;
    assign ok        = cmd_ok(cmd_q);
    assign idx       = {cmd_q.dspace, cmd_q.addr[MEM_AW-1:0]};
    assign wdata     = cmd_q.erase ? 8'hFF : cmd_q.data;
    assign wr_go     = exec && ok && !cmd_q.rd && !cmd_q.page;
    assign pg_put    = exec && ok && !cmd_q.rd && cmd_q.page;
    assign pg_commit = pg_put && (cmd_q.addr[PG_W-1:0] == PG_W'(PAGE_BYTES - 1));

    nvm_model #(.AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .idx       (idx),
        .rd_data   (rd_data),
        .wdata     (wdata),
        .wr_go     (wr_go),
        .pg_put    (pg_put),
        .pg_commit (pg_commit),
        .busy_o    (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)         sdo_o <= 1'b1;
        else if (busy)   sdo_o <= 1'b0;
        else if (load_s) sdo_o <= out_bit;
        else             sdo_o <= 1'b1;
    end

    // R6: a read latches the memory byte into the pending response
    assert_read_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (exec && ok && cmd_q.rd) |=> (resp_word[7:0] == $past(rd_data)));

    // R11: an ignored command starts no program cycle and zeroes the low byte
    assert_ignored_inert_R11: assert property (@(posedge clk) disable iff (rst)
        (exec && !ok) |=> (!$rose(busy) && resp_word[7:0] == 8'h00));

    // R7: busy only ever starts from an executed write during the low phase
    assert_busy_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wr_go || pg_commit) && !$past(load_s)));

    // R9: a buffer-only page load never raises busy
    assert_pg_fill_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (pg_put && !pg_commit) |=> !$rose(busy));
endmodule

// File: tb/sim_nvm_serial_port.sv
module sim_nvm_serial_port;
    localparam int H     = 6;
    localparam int WC    = 40;
    localparam int PB    = 8;
    localparam int LIMIT = 150000;

    logic clk = 1'b0, rst = 1'b1;
    logic load = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo;

    int checks = 0, errors = 0, cyc = 0;

    logic [7:0]  mem_m [2048];
    logic [7:0]  pbuf  [PB];
    logic [PB-1:0] pmask = '0;
    logic [31:0] exp_resp = '0;

    nvm_serial_port #(.WRITE_CYCLES(WC), .PAGE_BYTES(PB)) u0 (
        .clk(clk), .rst(rst), .load_i(load), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung (actual cycle %0d, expected < %0d)", cyc, LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit pg, bit dsp, bit csp, bit rd, bit er,
                                       int addr, int dat);
        return {pg, 1'b0, dsp, csp, 3'b000, rd, 1'b0, er, 4'b0000, 10'(addr), 8'(dat)};
    endfunction

    function automatic bit legal(logic [31:0] c);
        return !c[30] && c[27:25] == 3'd0 && !c[23] && c[21:18] == 4'd0 &&
               (c[29] != c[28]) && !(c[24] && c[22]);
    endfunction

    function automatic int loc(logic [31:0] c);
        return (c[29] ? 1024 : 0) + int'(c[17:8]);
    endfunction

    function automatic bit busy_exp(logic [31:0] c);
        return legal(c) && !c[24] && (!c[31] || c[10:8] == 3'd7);
    endfunction

    task automatic model(input logic [31:0] c);
        logic [7:0] d;
        int b;
        if (!legal(c))  exp_resp = {c[31:8], 8'h00};
        else if (c[24]) exp_resp = {c[31:8], mem_m[loc(c)]};
        else            exp_resp = c;
        if (legal(c) && !c[24]) begin
            d = c[22] ? 8'hFF : c[7:0];
            if (!c[31]) mem_m[loc(c)] = d;
            else begin
                pbuf[c[10:8]]  = d;
                pmask[c[10:8]] = 1'b1;
                if (c[10:8] == 3'd7) begin
                    b = loc(c) - 7;
                    for (int o = 0; o < PB; o++)
                        if (pmask[o]) mem_m[b + o] = pbuf[o];
                    pmask = '0;
                end
            end
        end
    endtask

    task automatic xfer(input logic [31:0] c, input int pulses, input string tag);
        logic [31:0] got;
        int n;
        load = 1'b1;
        for (int i = 31; i >= 0; i--) begin
            sdi = c[i]; sclk = 1'b0; tick(H);
            sclk = 1'b1; tick(H);
            got[i] = sdo;
        end
        check(got == exp_resp, tag, got, exp_resp);
        sclk = 1'b0; load = 1'b0; tick(H);
        sclk = 1'b1; tick(H);
        sclk = 1'b0; tick(H);
        if (pulses == 2) begin
            sclk = 1'b1; tick(H);
            if (busy_exp(c)) begin
                check(sdo == 1'b0, c[31] ? "R10 busy low" : "R7 busy low", 32'(sdo), 32'd0);
                sclk = 1'b0;
                n = H;
                while (sdo == 1'b0 && n < 1000) begin tick(1); n++; end
                check(n >= WC && n <= WC + 8, "R7 busy length", n, WC);
            end else begin
                check(sdo == 1'b1, c[31] ? "R9 no busy" : "R11 no busy", 32'(sdo), 32'd1);
                sclk = 1'b0; tick(H);
            end
            model(c);
        end
        tick(H);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem_m[i] = 8'hFF;
        tick(5);
        rst = 1'b0;
        tick(8);
        check(sdo == 1'b1, "R1 idle high", 32'(sdo), 32'd1);

        xfer(mk(0,0,1,0,0,5,'hA5), 2, "R1 first response zero");
        xfer(mk(0,0,1,1,0,5,0), 2, "R3 write echo");
        xfer(mk(0,1,0,1,0,5,0), 2, "R6 code read");
        xfer(mk(0,1,0,0,0,5,'h3C), 2, "R6 erased reads FF");
        xfer(mk(0,1,0,1,0,5,0), 2, "R5 write echo fields");
        xfer(mk(0,0,1,1,0,5,0), 2, "R12 data space read");
        xfer(mk(0,0,1,0,1,5,'h12), 2, "R12 code space kept");
        xfer(mk(0,0,1,1,0,5,0), 2, "R8 erase echo");
        xfer(mk(0,0,1,0,0,'h3FF,'h5A), 2, "R8 erase stored FF");
        xfer(mk(0,0,1,1,0,'h3FF,0), 2, "R2 msb first echo");
        xfer(mk(0,0,1,0,0,5,'h11) | 32'h4000_0000, 2, "R2 read top address");
        xfer(mk(0,1,1,0,0,5,'h22), 2, "R11 reserved ignored");
        xfer(mk(0,0,1,1,1,5,0), 2, "R11 both spaces ignored");
        xfer(mk(0,0,0,1,0,5,0), 2, "R11 read erase ignored");
        xfer(mk(0,0,1,1,0,5,0), 2, "R11 no space ignored");
        xfer(mk(0,0,1,0,0,9,'h66), 1, "R11 memory untouched");
        xfer(mk(0,0,1,1,0,9,0), 2, "R4 single pulse keeps response");
        xfer(mk(1,1,0,0,0,'h40,'h10), 2, "R4 single pulse no write");
        xfer(mk(1,1,0,0,0,'h42,'h20), 2, "R9 page load echo");
        xfer(mk(1,1,0,0,0,'h45,'h50), 2, "R9 page load echo");
        xfer(mk(0,1,0,1,0,'h42,0), 2, "R9 page load echo");
        xfer(mk(1,1,0,0,0,'h47,'h77), 2, "R9 buffer not in memory");
        xfer(mk(0,1,0,1,0,'h40,0), 2, "R10 commit echo");
        xfer(mk(0,1,0,1,0,'h42,0), 2, "R10 offset 0 committed");
        xfer(mk(0,1,0,1,0,'h45,0), 2, "R10 offset 2 committed");
        xfer(mk(0,1,0,1,0,'h47,0), 2, "R10 offset 5 committed");
        xfer(mk(0,1,0,1,0,'h41,0), 2, "R10 last offset committed");
        xfer(mk(1,1,0,0,0,'h87,'h99), 2, "R10 unbuffered offset erased");
        xfer(mk(0,1,0,1,0,'h80,0), 2, "R10 second commit echo");
        xfer(mk(0,1,0,1,0,'h87,0), 2, "R10 buffer emptied");
        xfer(mk(0,1,0,1,0,0,0), 2, "R10 lone byte committed");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule